// File: doc/BRIEF.md
# Self-Timed Flash Program and Erase Sequencer

This block models the automated internal operations of a byte-wide NOR flash array. It accepts one-cycle start pulses for a byte program, a sector erase or a chip erase, with an address and a data byte. It then runs the operation for a fixed number of clock cycles, updates a behavioural storage array and holds a busy flag for the whole run. The array is split into equal sectors, and the sector number is the upper part of the byte address. The default geometry is small (8 sectors of 64 bytes), and parameters take it up to the full 256 sectors of 512 bytes.

A read port returns array data when the block is idle. While an operation runs, a read returns a status byte instead. In that byte, bit 7 is the complement of the bit-7 value the operation will leave behind, and bit 6 flips on every read, so software can poll either bit to detect completion. A chip erase first fills the whole array with zeros and then erases the sectors one after another. A one-cycle done pulse marks the end of every operation.

Top module: `fsq_engine`

## Requirements
- R1: After reset, busy and done are 0 and every byte of the array reads FFh.
- R2: A start pulse sampled while idle makes busy 1 from the next cycle. If several start pulses arrive in the same cycle, chip erase wins over sector erase, and sector erase wins over program.
- R3: A byte program keeps busy high for exactly PROG_CYC cycles. It leaves the byte equal to its old value ANDed with the data, so bits can only be cleared.
- R4: A sector erase keeps busy high for exactly SERASE_CYC cycles. It sets every byte of the addressed sector to FFh and leaves the other sectors unchanged. The sector number is address bits ADDR_W-1 down to OFFS_W.
- R5: A chip erase keeps busy high for exactly PROG_CYC + NSECT*CERASE_CYC cycles: a zero fill, then one erase per sector. Afterwards every byte reads FFh.
- R6: A read while a program runs returns a status byte: bit 7 is the complement of data bit 7, and bits 5 to 0 are 0.
- R7: A read while a sector or chip erase runs returns bit 7 as 0, and bits 5 to 0 as 0.
- R8: Bit 6 of the status byte inverts on each read made while busy. Once busy has fallen, repeated reads return the same array byte.
- R9: Start pulses that arrive while busy are ignored. They neither change the array nor lengthen the running operation.
- R10: done is 1 for exactly one cycle, in the first cycle in which busy is 0 after an operation.
- R11: rd_data is updated one cycle after rd_en is sampled. When the block is idle, it holds the array byte at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_go | input | 1 | Start a byte program |
| sect_go | input | 1 | Start a sector erase |
| chip_go | input | 1 | Start a chip erase |
| addr | input | ADDR_W | Operation byte address (sector from its upper bits) |
| wdata | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Busy rises at the clock edge that samples a start pulse and stays high for exactly the operation's cycle count. The array update and the done pulse arrive together at the edge where busy falls. A read result appears one edge after its strobe. The bench drives inputs and samples outputs on the falling clock edge. It counts busy and done cycles in a falling-edge monitor that is cleared before each start pulse, and it compares those counts after one extra cycle past the fall of busy. Status reads are issued as back-to-back pairs in the first cycles of an operation, so both land while busy is still high.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
   typedef enum logic [2:0] {
      FSQ_IDLE,
      FSQ_PROG,
      FSQ_SERASE,
      FSQ_CZERO,
      FSQ_CERASE
   } fsq_state_t;
endpackage

// File: rtl/fsq_sector.sv
module fsq_sector #(
   parameter int OFFS_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_en,
   input  logic [OFFS_W-1:0] pgm_off,
   input  logic [7:0]        pgm_data,
   input  logic              ers_en,
   input  logic              zero_en,
   input  logic [OFFS_W-1:0] rd_off,
   output logic [7:0]        rd_byte
);
   localparam int SBYTES = 1 << OFFS_W;

   logic [7:0] mem [SBYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SBYTES; i++) mem[i] <= 8'hFF;
      end else if (zero_en) begin
         for (int i = 0; i < SBYTES; i++) mem[i] <= 8'h00;
      end else if (ers_en) begin
         for (int i = 0; i < SBYTES; i++) mem[i] <= 8'hFF;
      end else if (pgm_en) begin
         mem[pgm_off] <= mem[pgm_off] & pgm_data;
      end
   end

   assign rd_byte = mem[rd_off];
endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
   import fsq_pkg::*;
#(
   parameter int SECT_W     = 3,
   parameter int OFFS_W     = 6,
   parameter int PROG_CYC   = 4,
   parameter int SERASE_CYC = 12,
   parameter int CERASE_CYC = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     prog_go,
   input  logic                     sect_go,
   input  logic                     chip_go,
   input  logic [SECT_W+OFFS_W-1:0] addr,
   input  logic [7:0]               wdata,
   output logic                     busy,
   output logic                     done,
   output logic                     pgm_en,
   output logic                     ers_en,
   output logic                     zero_en,
   output logic [SECT_W+OFFS_W-1:0] op_addr,
   output logic [7:0]               op_data,
   output logic [SECT_W-1:0]        ers_sect,
   output logic                     stat_b7
);
   localparam int ADDR_W = SECT_W + OFFS_W;
   localparam int MAXC   = (PROG_CYC > SERASE_CYC) ?
                           ((PROG_CYC > CERASE_CYC) ? PROG_CYC : CERASE_CYC) :
                           ((SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC);
   localparam int CNT_W  = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0]  LD_PROG = CNT_W'(PROG_CYC - 1);
   localparam logic [CNT_W-1:0]  LD_SERS = CNT_W'(SERASE_CYC - 1);
   localparam logic [CNT_W-1:0]  LD_CERS = CNT_W'(CERASE_CYC - 1);
   localparam logic [SECT_W-1:0] LAST    = SECT_W'((1 << SECT_W) - 1);

   fsq_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [SECT_W-1:0] sidx;
   logic              fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= FSQ_IDLE;
         cnt     <= '0;
         sidx    <= '0;
         op_addr <= '0;
         op_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            FSQ_IDLE: begin
               sidx <= '0;
               if (chip_go) begin
                  state <= FSQ_CZERO;
                  cnt   <= LD_PROG;
               end else if (sect_go) begin
                  state <= FSQ_SERASE;
                  cnt   <= LD_SERS;
               end else if (prog_go) begin
                  state <= FSQ_PROG;
                  cnt   <= LD_PROG;
               end
               if (chip_go || sect_go || prog_go) begin
                  op_addr <= addr;
                  op_data <= wdata;
               end
            end
            FSQ_PROG, FSQ_SERASE: begin
               if (fire) begin
                  state <= FSQ_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FSQ_CZERO: begin
               if (fire) begin
                  state <= FSQ_CERASE;
                  cnt   <= LD_CERS;
                  sidx  <= '0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FSQ_CERASE: begin
               if (fire) begin
                  if (sidx == LAST) begin
                     state <= FSQ_IDLE;
                     done  <= 1'b1;
                  end else begin
                     sidx <= sidx + 1'b1;
                     cnt  <= LD_CERS;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= FSQ_IDLE;
         endcase
      end
   end

   assign fire     = (cnt == '0);
   assign busy     = (state != FSQ_IDLE);
   assign pgm_en   = (state == FSQ_PROG) && fire;
   assign ers_en   = ((state == FSQ_SERASE) || (state == FSQ_CERASE)) && fire;
   assign zero_en  = (state == FSQ_CZERO) && fire;
   assign ers_sect = (state == FSQ_CERASE) ? sidx : op_addr[ADDR_W-1:OFFS_W];
   assign stat_b7  = (state == FSQ_PROG) ? ~op_data[7] : 1'b0;
endmodule

// File: rtl/fsq_status.sv
module fsq_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  logic       busy,
   input  logic       stat_b7,
   input  logic [7:0] arr_byte,
   output logic [7:0] rd_data
);
   logic tog;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= 8'h00;
         tog     <= 1'b0;
      end else if (rd_en) begin
         if (busy) begin
            rd_data <= {stat_b7, tog, 6'b0};
            tog     <= ~tog;
         end else begin
            rd_data <= arr_byte;
         end
      end
   end
endmodule

// File: rtl/fsq_engine.sv
module fsq_engine #(
   parameter int SECT_W     = 3,
   parameter int OFFS_W     = 6,
   parameter int PROG_CYC   = 4,
   parameter int SERASE_CYC = 12,
   parameter int CERASE_CYC = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     prog_go,
   input  logic                     sect_go,
   input  logic                     chip_go,
   input  logic [SECT_W+OFFS_W-1:0] addr,
   input  logic [7:0]               wdata,
   input  logic                     rd_en,
   input  logic [SECT_W+OFFS_W-1:0] rd_addr,
   output logic [7:0]               rd_data,
   output logic                     busy,
   output logic                     done
);
   localparam int ADDR_W = SECT_W + OFFS_W;
   localparam int NSECT  = 1 << SECT_W;

   if (SECT_W < 1 || OFFS_W < 1) begin : g_bad_geom
      $error("fsq_engine: SECT_W and OFFS_W must be at least 1");
   end
   if (PROG_CYC < 1 || SERASE_CYC < 1 || CERASE_CYC < 1) begin : g_bad_time
      $error("fsq_engine: operation cycle counts must be at least 1");
   end

   logic                pgm_en, ers_en, zero_en, stat_b7;
   logic [ADDR_W-1:0]   op_addr;
   logic [7:0]          op_data;
   logic [SECT_W-1:0]   ers_sect;
   logic [7:0]          sec_rd [NSECT];
   logic [7:0]          arr_byte;

   fsq_ctrl #(
      .SECT_W(SECT_W), .OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC),
      .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .sect_go(sect_go),
      .chip_go(chip_go), .addr(addr), .wdata(wdata), .busy(busy),
      .done(done), .pgm_en(pgm_en), .ers_en(ers_en), .zero_en(zero_en),
      .op_addr(op_addr), .op_data(op_data), .ers_sect(ers_sect),
      .stat_b7(stat_b7)
   );

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      logic sel_pgm, sel_ers;
      assign sel_pgm = pgm_en && (op_addr[ADDR_W-1:OFFS_W] == SECT_W'(s));
      assign sel_ers = ers_en && (ers_sect == SECT_W'(s));
      fsq_sector #(.OFFS_W(OFFS_W)) u_sector (
         .clk(clk), .rst_n(rst_n), .pgm_en(sel_pgm),
         .pgm_off(op_addr[OFFS_W-1:0]), .pgm_data(op_data),
         .ers_en(sel_ers), .zero_en(zero_en),
         .rd_off(rd_addr[OFFS_W-1:0]), .rd_byte(sec_rd[s])
      );
   end

   assign arr_byte = sec_rd[rd_addr[ADDR_W-1:OFFS_W]];

   fsq_status u_status (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
      .stat_b7(stat_b7), .arr_byte(arr_byte), .rd_data(rd_data)
   );
endmodule

// File: rtl/fsq_engine_chk.sv
module fsq_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       prog_go,
   input logic       sect_go,
   input logic       chip_go,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       busy,
   input logic       done
);
   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (prog_go || sect_go || chip_go)) |=> busy);

   // R10
   done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10
   fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (rd_data[5:0] == 6'b0));

   // R8
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));
endmodule

bind fsq_engine fsq_engine_chk u_fsq_chk (
   .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .sect_go(sect_go),
   .chip_go(chip_go), .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
   .done(done)
);

// File: tb/fsq_engine_bench.sv
module fsq_engine_bench;
   localparam int SECT_W = 3, OFFS_W = 6, ADDR_W = SECT_W + OFFS_W;
   localparam int PROG_CYC = 4, SERASE_CYC = 12, CERASE_CYC = 6;
   localparam int CHIP_LEN = PROG_CYC + (1 << SECT_W) * CERASE_CYC;

   logic clk = 1'b0, rst_n = 1'b0;
   logic prog_go = 1'b0, sect_go = 1'b0, chip_go = 1'b0, rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0, rd_addr = '0;
   logic [7:0] wdata = '0, rd_data;
   logic busy, done;
   int errors = 0, checks = 0, busy_len = 0, done_cnt = 0, cyc = 0;

   fsq_engine #(.SECT_W(SECT_W), .OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC),
      .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)) u_fsq_engine (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .sect_go(sect_go),
      .chip_go(chip_go), .addr(addr), .wdata(wdata), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done));

   always #10 clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      if (busy) busy_len++;
      if (done) done_cnt++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd1(input logic [ADDR_W-1:0] a, output logic [7:0] d);
      rd_addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic rd2(input logic [ADDR_W-1:0] a, output logic [7:0] d1, output logic [7:0] d2);
      rd_addr = a; rd_en = 1'b1;
      @(negedge clk); d1 = rd_data;
      @(negedge clk); d2 = rd_data; rd_en = 1'b0;
   endtask

   task automatic start(input bit p, input bit s, input bit c,
                        input logic [ADDR_W-1:0] a, input logic [7:0] d);
      busy_len = 0; done_cnt = 0;
      prog_go = p; sect_go = s; chip_go = c; addr = a; wdata = d;
      @(negedge clk);
      prog_go = 0; sect_go = 0; chip_go = 0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
   endtask

   task automatic finish_op(input int exp_len, input string req);
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      @(negedge clk);
      chk(busy_len == exp_len, req, busy_len, exp_len);
      chk(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk(busy == 1'b0 && done == 1'b0, "R1 busy/done at reset", {busy, done}, 0);
      rd1(9'h000, d); chk(d == 8'hFF, "R1 R11 byte 000", d, 8'hFF);
      rd1(9'h1FF, d); chk(d == 8'hFF, "R1 R11 byte 1FF", d, 8'hFF);
   endtask

   task automatic t_program(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic [7:0] exp);
      logic [7:0] s1, s2, r1, r2;
      start(1, 0, 0, a, d);
      rd2(a, s1, s2);
      chk(s1[7] == ~d[7], "R6 program status bit7", s1[7], ~d[7]);
      chk(s1[5:0] == 0, "R6 status low bits", s1[5:0], 0);
      chk(s1[6] != s2[6], "R8 toggle during program", s2[6], ~s1[6]);
      finish_op(PROG_CYC, "R3 program busy length");
      rd2(a, r1, r2);
      chk(r1 == exp, "R3 R11 programmed byte", r1, exp);
      chk(r1 == r2, "R8 no toggle when idle", r2, r1);
   endtask

   task automatic t_sector_ignore();
      logic [7:0] s1, s2, r;
      start(0, 1, 0, 9'h003, 8'h00);
      rd2(9'h005, s1, s2);
      chk(s1[7] == 1'b0, "R7 sector erase status bit7", s1[7], 0);
      chk(s1[6] != s2[6], "R8 toggle during erase", s2[6], ~s1[6]);
      prog_go = 1; addr = 9'h005; wdata = 8'h00;
      @(negedge clk); prog_go = 0;
      finish_op(SERASE_CYC, "R4 R9 sector erase busy length");
      rd1(9'h005, r); chk(r == 8'hFF, "R4 R9 erased byte, program ignored", r, 8'hFF);
      rd1(9'h045, r); chk(r == 8'h12, "R4 other sector unchanged", r, 8'h12);
   endtask

   task automatic t_priority_sect();
      logic [7:0] r;
      start(1, 1, 0, 9'h045, 8'h00);
      finish_op(SERASE_CYC, "R2 sector beats program length");
      rd1(9'h045, r); chk(r == 8'hFF, "R2 sector beats program data", r, 8'hFF);
   endtask

   task automatic t_chip();
      logic [7:0] s1, s2, r;
      start(1, 1, 1, 9'h1FF, 8'h00);
      rd2(9'h100, s1, s2);
      chk(s1[7] == 1'b0, "R7 chip erase status bit7", s1[7], 0);
      chk(s1[6] != s2[6], "R8 toggle during chip erase", s2[6], ~s1[6]);
      finish_op(CHIP_LEN, "R5 R2 chip erase busy length");
      rd1(9'h1FF, r); chk(r == 8'hFF, "R5 byte 1FF erased", r, 8'hFF);
      rd1(9'h100, r); chk(r == 8'hFF, "R5 byte 100 erased", r, 8'hFF);
      rd1(9'h000, r); chk(r == 8'hFF, "R5 byte 000 erased", r, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program(9'h005, 8'hF0, 8'hF0);
      t_program(9'h005, 8'h3C, 8'h30);
      t_program(9'h045, 8'h12, 8'h12);
      t_sector_ignore();
      t_priority_sect();
      t_program(9'h1FF, 8'h00, 8'h00);
      t_program(9'h100, 8'h55, 8'h55);
      t_chip();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule